// File: doc/BRIEF.md
# Miss-Triggered Thread Switch Controller

This controller decides which of several hardware thread contexts owns a single shared issue pipeline. The running thread keeps the pipeline until it reports a cache miss. On a miss the controller parks that thread as waiting and hands the pipeline to the next ready thread on the following cycle. A waiting thread becomes schedulable again only when a fill-complete pulse tagged with its ID arrives. When no thread is ready, issue is withheld until a fill returns.

One thread may be marked as the priority thread. Whenever it is ready it owns the pipeline. Enabling the priority setting for a ready thread, or completing that thread's fill, moves it onto the pipeline on the next cycle, and it is not switched out until it misses itself.

The register file is split into groups. Each thread holds its own enable mask over those groups, and every register-group access by the running thread is checked against that mask. An access to a disabled group raises a one-cycle violation flag that carries the thread ID and the group number.

Top module: `mtsw_ctrl`

## Requirements
- R1: After reset, thread 0 is running, issue enable is high, every thread is ready, every thread's group mask is all ones (all groups enabled), and no violation is flagged.
- R2: A miss while issue enable is high moves the pipeline to another ready thread one cycle later, and the missing thread becomes waiting.
- R3: The replacement thread is the first ready thread in increasing ID order after the thread that last ran, wrapping from the highest ID to 0.
- R4: A waiting thread is never selected until a fill pulse carrying its ID arrives.
- R5: When no thread is ready, issue enable goes low one cycle later and stays low, with the thread ID output holding the last running thread, until a fill arrives. The filled thread then runs on the next cycle.
- R6: While priority is enabled and the priority thread is ready, that thread is running on the next cycle. This covers the cycle after its fill completes and the cycle after priority is turned on for a ready thread.
- R7: Without a miss, and with no priority thread taking over, the running thread keeps the pipeline. There is no time slice.
- R8: A miss and a fill for the running thread in the same cycle still cause a switch, but the thread ends up ready and can be selected again by round-robin.
- R9: A mask write loads the enable vector of the named thread only, and bit g of the vector enables group g. The new mask applies from the next cycle.
- R10: An access by the running thread to a group whose mask bit is 0 sets the violation flag on the next cycle, with the running thread's ID and the group number. An access to an enabled group leaves the flag low.
- R11: While issue enable is low, misses and register-group accesses are ignored: they change no schedule and raise no violation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| miss_i | input | 1 | Cache-miss pulse from the running thread |
| fill_vld_i | input | 1 | Fill-complete pulse |
| fill_tid_i | input | 2 | Thread ID of the completed fill |
| prio_en_i | input | 1 | Priority thread enable |
| prio_tid_i | input | 2 | ID of the priority thread |
| mask_wr_i | input | 1 | Group-mask write strobe |
| mask_tid_i | input | 2 | Thread whose mask is written |
| mask_val_i | input | 8 | New group enable vector |
| acc_vld_i | input | 1 | Register-group access by the running thread |
| acc_grp_i | input | 3 | Group number of the access |
| cur_tid_o | output | 2 | Thread currently owning the pipeline |
| issue_en_o | output | 1 | Pipeline may issue for cur_tid_o |
| viol_o | output | 1 | Access violation, one cycle |
| viol_tid_o | output | 2 | Thread that made the violating access |
| viol_grp_o | output | 3 | Group of the violating access |

## Verification
The properties assume that fill pulses only name threads that really are waiting, that a miss is only reported by the thread shown on cur_tid_o, and that the priority configuration is sampled together with the fills it qualifies. Group numbers are assumed to lie below the group count. The stimulus follows a scripted schedule in which fills are issued only for threads that the script itself has parked with a miss. The one deliberate exception is a miss paired with a same-cycle fill of the running thread. Priority changes are made only in cycles that carry no other event.

// File: rtl/mtsw_pkg.sv
package mtsw_pkg;
  // default geometry shared by the controller and its checker
  localparam int unsigned THR_N_DEF = 4;
  localparam int unsigned GRP_N_DEF = 8;
endpackage

// File: rtl/mtsw_rr_pick.sv
// Round-robin picker: first set request strictly after 'last', wrapping.
module mtsw_rr_pick #(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = 2
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] last_i,
  output logic          ok_o,
  output logic [IW-1:0] pick_o
);
  int unsigned idx;

  always_comb begin
    ok_o   = 1'b0;
    pick_o = last_i;
    idx    = 0;
    // walk from farthest to nearest so the nearest hit is written last
    for (int unsigned k = N; k >= 1; k--) begin
      idx = (int'(last_i) + k) % N;
      if (req_i[idx]) begin
        ok_o   = 1'b1;
        pick_o = IW'(idx);
      end
    end
  end
endmodule

// File: rtl/mtsw_grp_guard.sv
// Per-thread register-group enable masks and access checking.
module mtsw_grp_guard #(
  parameter int unsigned THR_N = 4,
  parameter int unsigned GRP_N = 8,
  parameter int unsigned TW    = 2,
  parameter int unsigned GW    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [TW-1:0]    wr_tid_i,
  input  logic [GRP_N-1:0] wr_mask_i,
  input  logic             acc_vld_i,
  input  logic [TW-1:0]    acc_tid_i,
  input  logic [GW-1:0]    acc_grp_i,
  output logic             viol_o,
  output logic [TW-1:0]    viol_tid_o,
  output logic [GW-1:0]    viol_grp_o
);
  logic [THR_N-1:0][GRP_N-1:0] mask_q, mask_d;
  logic                        viol_d;

  for (genvar t = 0; t < THR_N; t++) begin : g_mask
    assign mask_d[t] = (wr_i && (wr_tid_i == TW'(t))) ? wr_mask_i : mask_q[t];
  end

  assign viol_d = acc_vld_i && !mask_q[acc_tid_i][acc_grp_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q     <= '1;
      viol_o     <= 1'b0;
      viol_tid_o <= '0;
      viol_grp_o <= '0;
    end else begin
      mask_q <= mask_d;
      viol_o <= viol_d;
      if (acc_vld_i) begin
        viol_tid_o <= acc_tid_i;
        viol_grp_o <= acc_grp_i;
      end
    end
  end
endmodule

// File: rtl/mtsw_ctrl.sv
module mtsw_ctrl
  import mtsw_pkg::*;
#(
  parameter int unsigned THR_N = THR_N_DEF,
  parameter int unsigned GRP_N = GRP_N_DEF,
  localparam int unsigned TW   = (THR_N > 1) ? $clog2(THR_N) : 1,
  localparam int unsigned GW   = (GRP_N > 1) ? $clog2(GRP_N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             miss_i,
  input  logic             fill_vld_i,
  input  logic [TW-1:0]    fill_tid_i,
  input  logic             prio_en_i,
  input  logic [TW-1:0]    prio_tid_i,
  input  logic             mask_wr_i,
  input  logic [TW-1:0]    mask_tid_i,
  input  logic [GRP_N-1:0] mask_val_i,
  input  logic             acc_vld_i,
  input  logic [GW-1:0]    acc_grp_i,
  output logic [TW-1:0]    cur_tid_o,
  output logic             issue_en_o,
  output logic             viol_o,
  output logic [TW-1:0]    viol_tid_o,
  output logic [GW-1:0]    viol_grp_o
);
  localparam logic [THR_N-1:0] ONE_HOT0 = THR_N'(1);

  logic [THR_N-1:0] rdy_q, rdy_d, park_set, wake_set;
  logic [TW-1:0]    cur_q, cur_d, rr_pick;
  logic             run_q, run_d, rr_ok, miss_eff, prio_hit;

  // miss is applied first, then the fill: a same-cycle pair leaves it ready
  assign miss_eff = miss_i && run_q;
  assign park_set = miss_eff ? (ONE_HOT0 << cur_q) : '0;
  assign wake_set = fill_vld_i ? (ONE_HOT0 << fill_tid_i) : '0;
  assign rdy_d    = (rdy_q & ~park_set) | wake_set;
  assign prio_hit = prio_en_i && rdy_d[prio_tid_i];

  mtsw_rr_pick #(.N(THR_N), .IW(TW)) u_rr (
    .req_i  (rdy_d),
    .last_i (cur_q),
    .ok_o   (rr_ok),
    .pick_o (rr_pick)
  );

  always_comb begin
    cur_d = cur_q;
    run_d = run_q;
    if (prio_hit) begin
      cur_d = prio_tid_i;
      run_d = 1'b1;
    end else if (run_q && !miss_i) begin
      cur_d = cur_q;
      run_d = 1'b1;
    end else if (rr_ok) begin
      cur_d = rr_pick;
      run_d = 1'b1;
    end else begin
      run_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q <= '1;
      cur_q <= '0;
      run_q <= 1'b1;
    end else begin
      rdy_q <= rdy_d;
      cur_q <= cur_d;
      run_q <= run_d;
    end
  end

  mtsw_grp_guard #(.THR_N(THR_N), .GRP_N(GRP_N), .TW(TW), .GW(GW)) u_guard (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (mask_wr_i),
    .wr_tid_i   (mask_tid_i),
    .wr_mask_i  (mask_val_i),
    .acc_vld_i  (acc_vld_i && run_q),
    .acc_tid_i  (cur_q),
    .acc_grp_i  (acc_grp_i),
    .viol_o     (viol_o),
    .viol_tid_o (viol_tid_o),
    .viol_grp_o (viol_grp_o)
  );

  assign cur_tid_o  = cur_q;
  assign issue_en_o = run_q;
endmodule

// File: rtl/mtsw_ctrl_chk.sv
module mtsw_ctrl_chk #(
  parameter int unsigned THR_N = 4,
  parameter int unsigned GRP_N = 8,
  localparam int unsigned TW   = (THR_N > 1) ? $clog2(THR_N) : 1,
  localparam int unsigned GW   = (GRP_N > 1) ? $clog2(GRP_N) : 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          miss_i,
  input logic          fill_vld_i,
  input logic [TW-1:0] fill_tid_i,
  input logic          prio_en_i,
  input logic [TW-1:0] prio_tid_i,
  input logic          acc_vld_i,
  input logic [GW-1:0] acc_grp_i,
  input logic [TW-1:0] cur_tid_o,
  input logic          issue_en_o,
  input logic          viol_o,
  input logic [TW-1:0] viol_tid_o,
  input logic [GW-1:0] viol_grp_o
);
  // R2 / R4: a thread that missed without a same-cycle fill is not running next
  p_miss_leaves_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_i && issue_en_o && !(fill_vld_i && fill_tid_i == cur_tid_o))
      |=> !(issue_en_o && cur_tid_o == $past(cur_tid_o)));

  // R6: fill of the priority thread puts it on the pipeline next cycle
  p_prio_preempt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prio_en_i && fill_vld_i && fill_tid_i == prio_tid_i)
      |=> (issue_en_o && cur_tid_o == $past(prio_tid_i)));

  // R7: no event, no switch
  p_no_timeslice_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_en_o && !miss_i && !fill_vld_i && !prio_en_i)
      |=> (issue_en_o && $stable(cur_tid_o)));

  // R5: idle persists until a fill arrives
  p_idle_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!issue_en_o && !fill_vld_i) |=> !issue_en_o);

  // R10 / R11: a violation traces back to an access made while issuing
  p_viol_source_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> ($past(acc_vld_i && issue_en_o)
                && viol_tid_o == $past(cur_tid_o)
                && viol_grp_o == $past(acc_grp_i)));
endmodule

bind mtsw_ctrl mtsw_ctrl_chk #(.THR_N(THR_N), .GRP_N(GRP_N)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .miss_i     (miss_i),
  .fill_vld_i (fill_vld_i),
  .fill_tid_i (fill_tid_i),
  .prio_en_i  (prio_en_i),
  .prio_tid_i (prio_tid_i),
  .acc_vld_i  (acc_vld_i),
  .acc_grp_i  (acc_grp_i),
  .cur_tid_o  (cur_tid_o),
  .issue_en_o (issue_en_o),
  .viol_o     (viol_o),
  .viol_tid_o (viol_tid_o),
  .viol_grp_o (viol_grp_o)
);

// File: tb/mtsw_ctrl_test.sv
module mtsw_ctrl_test;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_ni;
  logic       miss_i, fill_vld_i, prio_en_i, mask_wr_i, acc_vld_i;
  logic [1:0] fill_tid_i, prio_tid_i, mask_tid_i;
  logic [7:0] mask_val_i;
  logic [2:0] acc_grp_i;
  logic [1:0] cur_tid_o, viol_tid_o;
  logic       issue_en_o, viol_o;
  logic [2:0] viol_grp_o;

  int n_chk  = 0;
  int n_fail = 0;

  typedef struct {
    logic       en;
    logic [1:0] tid;
    logic       viol;
    logic [1:0] vtid;
    logic [2:0] vgrp;
    string      req;
  } exp_t;

  exp_t sb_q[$];

  always #(CLK_P/2) clk = ~clk;

  mtsw_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .miss_i(miss_i),
    .fill_vld_i(fill_vld_i), .fill_tid_i(fill_tid_i),
    .prio_en_i(prio_en_i), .prio_tid_i(prio_tid_i),
    .mask_wr_i(mask_wr_i), .mask_tid_i(mask_tid_i), .mask_val_i(mask_val_i),
    .acc_vld_i(acc_vld_i), .acc_grp_i(acc_grp_i),
    .cur_tid_o(cur_tid_o), .issue_en_o(issue_en_o),
    .viol_o(viol_o), .viol_tid_o(viol_tid_o), .viol_grp_o(viol_grp_o)
  );

  task automatic clear_pulses();
    miss_i = 0; fill_vld_i = 0; fill_tid_i = 0;
    mask_wr_i = 0; mask_tid_i = 0; mask_val_i = 0;
    acc_vld_i = 0; acc_grp_i = 0;
  endtask

  // driver: push what the ports must show after the coming edge, then clock
  task automatic go(string req, logic en, logic [1:0] tid,
                    logic viol = 1'b0, logic [1:0] vt = 2'd0, logic [2:0] vg = 3'd0);
    exp_t e;
    e.en = en; e.tid = tid; e.viol = viol; e.vtid = vt; e.vgrp = vg; e.req = req;
    sb_q.push_back(e);
    @(posedge clk);
    @(negedge clk);
    clear_pulses();
  endtask

  // monitor: compare a quarter period after each edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_chk++;
        if (issue_en_o !== e.en || cur_tid_o !== e.tid || viol_o !== e.viol ||
            (e.viol && (viol_tid_o !== e.vtid || viol_grp_o !== e.vgrp))) begin
          n_fail++;
          $display("FAIL %s: got en=%0b tid=%0d viol=%0b vt=%0d vg=%0d, expected en=%0b tid=%0d viol=%0b vt=%0d vg=%0d",
                   e.req, issue_en_o, cur_tid_o, viol_o, viol_tid_o, viol_grp_o,
                   e.en, e.tid, e.viol, e.vtid, e.vgrp);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run still going after 5000 cycles (expected to end earlier)");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    prio_en_i = 0; prio_tid_i = 0;
    clear_pulses();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    n_chk++;
    if (issue_en_o !== 1'b1 || cur_tid_o !== 2'd0 || viol_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: got en=%0b tid=%0d viol=%0b, expected en=1 tid=0 viol=0",
               issue_en_o, cur_tid_o, viol_o);
    end

    acc_vld_i = 1; acc_grp_i = 3'd7;       go("R1 masks all enabled", 1, 0);
    miss_i = 1;                            go("R2 switch on miss", 1, 1);
    miss_i = 1;                            go("R3 next after 1", 1, 2);
    fill_vld_i = 1; fill_tid_i = 0;        go("R7 fill does not preempt", 1, 2);
    miss_i = 1;                            go("R3 next after 2", 1, 3);
    miss_i = 1;                            go("R3 wrap to 0", 1, 0);
    miss_i = 1;                            go("R5 none ready", 0, 0);
    miss_i = 1; acc_vld_i = 1;             go("R11 miss while idle", 0, 0);
    fill_vld_i = 1; fill_tid_i = 2;        go("R4 waiting 1 skipped", 1, 2);
    fill_vld_i = 1; fill_tid_i = 1;        go("R7 hold", 1, 2);
    fill_vld_i = 1; fill_tid_i = 3;        go("R7 hold", 1, 2);
    fill_vld_i = 1; fill_tid_i = 0;        go("R7 hold", 1, 2);
    miss_i = 1; fill_vld_i = 1; fill_tid_i = 2;
                                           go("R8 switch on miss+fill", 1, 3);
    miss_i = 1;                            go("R3 wrap", 1, 0);
    miss_i = 1;                            go("R3 next", 1, 1);
    miss_i = 1;                            go("R8 thread 2 still ready", 1, 2);
    miss_i = 1;                            go("R5 idle holds last id", 0, 2);
    fill_vld_i = 1; fill_tid_i = 0;        go("R5 filled thread runs", 1, 0);
    fill_vld_i = 1; fill_tid_i = 1;        go("R7 hold", 1, 0);
    fill_vld_i = 1; fill_tid_i = 2;        go("R7 hold", 1, 0);
    fill_vld_i = 1; fill_tid_i = 3;        go("R7 hold", 1, 0);
    prio_en_i = 1; prio_tid_i = 3;         go("R6 priority enable takes over", 1, 3);
    miss_i = 1;                            go("R2 priority thread misses", 1, 0);
    miss_i = 1;                            go("R3 next", 1, 1);
    fill_vld_i = 1; fill_tid_i = 3;        go("R6 preempt on priority fill", 1, 3);
                                           go("R6 priority keeps pipeline", 1, 3);
    prio_en_i = 0;                         go("R7 hold after priority off", 1, 3);
    mask_wr_i = 1; mask_tid_i = 3; mask_val_i = 8'hF7;
                                           go("R9 mask write", 1, 3);
    acc_vld_i = 1; acc_grp_i = 3'd3;       go("R10 disabled group", 1, 3, 1, 3, 3);
    acc_vld_i = 1; acc_grp_i = 3'd2;       go("R10 enabled group", 1, 3);
    mask_wr_i = 1; mask_tid_i = 1; mask_val_i = 8'h00;
    acc_vld_i = 1; acc_grp_i = 3'd0;       go("R9 other thread mask", 1, 3);
    miss_i = 1;                            go("R4 waiting 0 skipped", 1, 1);
    acc_vld_i = 1; acc_grp_i = 3'd5;       go("R9 thread 1 mask cleared", 1, 1, 1, 1, 5);
    miss_i = 1;                            go("R3 next", 1, 2);
    miss_i = 1;                            go("R5 none ready", 0, 2);
    mask_wr_i = 1; mask_tid_i = 2; mask_val_i = 8'h00;
                                           go("R5 idle", 0, 2);
    acc_vld_i = 1; acc_grp_i = 3'd4;       go("R11 access while idle", 0, 2);
    fill_vld_i = 1; fill_tid_i = 2;        go("R5 filled thread runs", 1, 2);
    acc_vld_i = 1; acc_grp_i = 3'd4;       go("R11 same access while issuing", 1, 2, 1, 2, 4);

    wait (sb_q.size() == 0);
    #(CLK_P);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule